// File: doc/BRIEF.md
# Instrument Event Status Register Set

This block gathers the status of an instrument's remote-control interface. Single-cycle event pulses are caught in an event register: power-up, a command that could not be parsed, a command the instrument cannot carry out, a query whose reply was lost, and the completion of pending work. Each event bit stays set until the register is read or a clear-all command arrives. A programmable enable register selects which event bits count toward a summary flag. That flag is published in a status byte for the service-request logic that sits outside this block.

Reading the event register is destructive. The read strobe returns the current value and empties the register at the same clock edge. The status byte holds no state of its own and follows the masked event register combinationally. Operation-complete reporting must be armed first. Once armed, it fires when the pending-operations busy input is seen low.

Top module: `evt_status_unit`

## Requirements
- R1: Event bit positions are: power-on bit 7, command error bit 5, execution error bit 4, query error bit 2, operation complete bit 0. Bits 6, 3 and 1 of the event and enable read outputs are always 0.
- R2: An event bit, once set by its strobe, stays set over any number of cycles until a read strobe or clear-all strobe is applied.
- R3: In the cycle `evtReadStb` is high, `evtRdData` shows the register contents. From the next cycle on, those bits are cleared.
- R4: An event strobe in the same cycle as a read or clear-all strobe is not lost. It is absent from the value returned in that cycle and present in the register afterwards.
- R5: `clearAllStb` empties the event register and cancels an armed operation-complete request, but leaves the enable register unchanged.
- R6: While `rstN` is low, the event, enable and status byte outputs are 0. At the first clock edge after release, the event register becomes 0x80 (power-on bit only).
- R7: A write with `enWrEn` loads `enWrData` into the enable register; `enRdData` then reads back exactly that value with bits 6, 3 and 1 forced to 0. Writing 0 disables every event.
- R8: `statusByte` bit 5 equals the OR over bits of (event AND enable) in the same cycle, with no latching of its own. All other status byte bits are 0.
- R9: Bit 0 is set only at a clock edge where an operation-complete request armed by `opcArm` is pending and `opsBusy` is low. That edge also disarms the request, so a later drop of `opsBusy` with no new arming sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| pwrOnStb | input | 1 | Power-on event pulse |
| cmdErrStb | input | 1 | Command error event pulse |
| execErrStb | input | 1 | Execution error event pulse |
| queryErrStb | input | 1 | Query error event pulse |
| opcArm | input | 1 | Arms an operation-complete request |
| opsBusy | input | 1 | High while operations are still pending |
| evtReadStb | input | 1 | Read-and-clear of the event register |
| clearAllStb | input | 1 | Clears events and cancels the armed request |
| enWrEn | input | 1 | Enable register write strobe |
| enWrData | input | 8 | Enable register write value |
| evtRdData | output | 8 | Event register value |
| enRdData | output | 8 | Enable register value |
| statusByte | output | 8 | Status byte with the summary on bit 5 |

## Verification
The hardest case to reach is an event strobe that lands in the very cycle the register is emptied. The read output and the next register value then disagree on purpose. The stimulus raises `cmdErrStb` on the same falling edge as `evtReadStb` or `clearAllStb`. It records the returned value before the edge and the register value after it. A second hard case is an armed operation-complete request that a clear-all cancels while `opsBusy` is still high. The stimulus holds busy through the clear, drops it afterwards and confirms that bit 0 never appears.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_PON = 7;
  localparam int BIT_CMD = 5;
  localparam int BIT_EXE = 4;
  localparam int BIT_QRY = 2;
  localparam int BIT_OPC = 0;
  localparam int SUM_BIT = 5;

  localparam logic [REG_W-1:0] USED_MASK =
    REG_W'((1 << BIT_PON) | (1 << BIT_CMD) | (1 << BIT_EXE) | (1 << BIT_QRY) | (1 << BIT_OPC));

  typedef struct packed {
    logic [REG_W-1:0] setBits;   // bits to set this cycle
    logic             clearEvt;  // empty the event register
    logic             enWrite;   // load the enable register
  } ctlStrobes_t;
endpackage

// File: rtl/evt_status_ctrl.sv
module evt_status_ctrl
  import evt_status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrOnStb,
  input  logic        cmdErrStb,
  input  logic        execErrStb,
  input  logic        queryErrStb,
  input  logic        opcArm,
  input  logic        opsBusy,
  input  logic        evtReadStb,
  input  logic        clearAllStb,
  input  logic        enWrEn,
  output ctlStrobes_t strobes
);
  logic ponDone;
  logic opcArmed;
  logic opcFire;
  logic [REG_W-1:0] rawSet;

  // Completion fires when a request is pending and the work has drained
  assign opcFire = opcArmed && !opsBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ponDone  <= 1'b0;
      opcArmed <= 1'b0;
    end else begin
      ponDone <= 1'b1;
      if (clearAllStb)  opcArmed <= 1'b0;
      else if (opcFire) opcArmed <= 1'b0;
      else if (opcArm)  opcArmed <= 1'b1;
    end
  end

  always_comb begin
    rawSet          = '0;
    rawSet[BIT_PON] = pwrOnStb || !ponDone;
    rawSet[BIT_CMD] = cmdErrStb;
    rawSet[BIT_EXE] = execErrStb;
    rawSet[BIT_QRY] = queryErrStb;
    rawSet[BIT_OPC] = opcFire;
  end

  always_comb begin
    strobes.setBits  = rawSet & USED_MASK;
    strobes.clearEvt = evtReadStb || clearAllStb;
    strobes.enWrite  = enWrEn;
  end
endmodule

// File: rtl/evt_status_dp.sv
module evt_status_dp
  import evt_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [REG_W-1:0] enWrData,
  output logic [REG_W-1:0] evtReg,
  output logic [REG_W-1:0] enReg,
  output logic             summary
);
  for (genvar b = 0; b < REG_W; b++) begin : g_evt
    if (USED_MASK[b]) begin : g_used
      logic bitQ;
      // A set in the clearing cycle survives the clear
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) bitQ <= 1'b0;
        else       bitQ <= (strobes.clearEvt ? 1'b0 : bitQ) | strobes.setBits[b];
      end
      assign evtReg[b] = bitQ;
    end else begin : g_unused
      assign evtReg[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               enReg <= '0;
    else if (strobes.enWrite) enReg <= enWrData & USED_MASK;
  end

  assign summary = |(evtReg & enReg);
endmodule

// File: rtl/evt_status_unit.sv
module evt_status_unit
  import evt_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrOnStb,
  input  logic             cmdErrStb,
  input  logic             execErrStb,
  input  logic             queryErrStb,
  input  logic             opcArm,
  input  logic             opsBusy,
  input  logic             evtReadStb,
  input  logic             clearAllStb,
  input  logic             enWrEn,
  input  logic [REG_W-1:0] enWrData,
  output logic [REG_W-1:0] evtRdData,
  output logic [REG_W-1:0] enRdData,
  output logic [REG_W-1:0] statusByte
);
  ctlStrobes_t strobes;
  logic        summary;

  evt_status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pwrOnStb(pwrOnStb), .cmdErrStb(cmdErrStb),
    .execErrStb(execErrStb), .queryErrStb(queryErrStb), .opcArm(opcArm),
    .opsBusy(opsBusy), .evtReadStb(evtReadStb), .clearAllStb(clearAllStb),
    .enWrEn(enWrEn), .strobes(strobes)
  );

  evt_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .enWrData(enWrData),
    .evtReg(evtRdData), .enReg(enRdData), .summary(summary)
  );

  always_comb begin
    statusByte          = '0;
    statusByte[SUM_BIT] = summary;
  end
endmodule

// File: rtl/evt_status_chk.sv
module evt_status_chk
  import evt_status_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cmdErrStb,
  input logic             execErrStb,
  input logic             queryErrStb,
  input logic             opsBusy,
  input logic             evtReadStb,
  input logic             clearAllStb,
  input logic             enWrEn,
  input logic [REG_W-1:0] evtRdData,
  input logic [REG_W-1:0] enRdData,
  input logic [REG_W-1:0] statusByte
);
  localparam logic [REG_W-1:0] ERR_MASK =
    REG_W'((1 << BIT_CMD) | (1 << BIT_EXE) | (1 << BIT_QRY));

  p_unused_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    ((evtRdData | enRdData) & ~USED_MASK) == '0);

  p_bits_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!evtReadStb && !clearAllStb) |=> ((evtRdData & $past(evtRdData)) == $past(evtRdData)));

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (evtReadStb && !cmdErrStb && !execErrStb && !queryErrStb) |=> ((evtRdData & ERR_MASK) == '0));

  p_event_survives_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((evtReadStb || clearAllStb) && cmdErrStb) |=> evtRdData[BIT_CMD]);

  p_enable_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clearAllStb && !enWrEn) |=> $stable(enRdData));

  p_summary_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusByte == (REG_W'(|(evtRdData & enRdData)) << SUM_BIT));

  p_opc_needs_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtRdData[BIT_OPC]) |-> $past(!opsBusy));
endmodule

bind evt_status_unit evt_status_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdErrStb(cmdErrStb), .execErrStb(execErrStb),
  .queryErrStb(queryErrStb), .opsBusy(opsBusy), .evtReadStb(evtReadStb),
  .clearAllStb(clearAllStb), .enWrEn(enWrEn), .evtRdData(evtRdData),
  .enRdData(enRdData), .statusByte(statusByte)
);

// File: tb/evt_status_unit_tb.sv
`timescale 1ns/1ps
module evt_status_unit_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrOnStb = 0, cmdErrStb = 0, execErrStb = 0, queryErrStb = 0;
  logic opcArm = 0, opsBusy = 0, evtReadStb = 0, clearAllStb = 0, enWrEn = 0;
  logic [7:0] enWrData = '0;
  logic [7:0] evtRdData, enRdData, statusByte;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_status_unit u_dut (.*);

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic writeEn(input logic [7:0] v);
    enWrEn = 1; enWrData = v; step(); enWrEn = 0;
  endtask

  task automatic readEvt(output logic [7:0] v);
    v = evtRdData; evtReadStb = 1; step(); evtReadStb = 0;
  endtask

  task automatic t_reset();
    step(3);
    check("R6", "event in reset", evtRdData, 8'h00);
    check("R6", "enable in reset", enRdData, 8'h00);
    check("R6", "status in reset", statusByte, 8'h00);
    rstN = 1; step();
    check("R6", "power-on bit after release", evtRdData, 8'h80);
  endtask

  task automatic t_layout();
    logic [7:0] v;
    readEvt(v);
    cmdErrStb = 1; execErrStb = 1; queryErrStb = 1; pwrOnStb = 1; step();
    cmdErrStb = 0; execErrStb = 0; queryErrStb = 0; pwrOnStb = 0;
    check("R1", "all error bits layout", evtRdData, 8'hB4);
    readEvt(v);
    check("R3", "read returns value", v, 8'hB4);
    check("R3", "register empty after read", evtRdData, 8'h00);
    writeEn(8'hFF);
    check("R7", "enable masked readback", enRdData, 8'hB5);
    writeEn(8'h00);
  endtask

  task automatic t_latch();
    execErrStb = 1; step(); execErrStb = 0;
    step(20);
    check("R2", "bit held many cycles", evtRdData, 8'h10);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    cmdErrStb = 1; readEvt(v); cmdErrStb = 0;
    check("R4", "read value excludes new event", v, 8'h10);
    check("R4", "new event kept after read", evtRdData, 8'h20);
    clearAllStb = 1; queryErrStb = 1; step(); clearAllStb = 0; queryErrStb = 0;
    check("R4", "event kept after clear-all", evtRdData, 8'h04);
    readEvt(v);
  endtask

  task automatic t_summary();
    logic [7:0] v;
    writeEn(8'h14);
    check("R7", "enable exact readback", enRdData, 8'h14);
    execErrStb = 1; step(); execErrStb = 0;
    check("R8", "summary raised", statusByte, 8'h20);
    cmdErrStb = 1; step(); cmdErrStb = 0;
    writeEn(8'h00);
    check("R8", "summary drops with enable 0", statusByte, 8'h00);
    writeEn(8'h20);
    check("R8", "summary from cmd bit", statusByte, 8'h20);
    readEvt(v);
    check("R8", "summary drops on read", statusByte, 8'h00);
  endtask

  task automatic t_clear_all();
    writeEn(8'h35);
    cmdErrStb = 1; execErrStb = 1; step(); cmdErrStb = 0; execErrStb = 0;
    clearAllStb = 1; step(); clearAllStb = 0;
    check("R5", "events emptied", evtRdData, 8'h00);
    check("R5", "enable kept", enRdData, 8'h35);
    check("R5", "status cleared", statusByte, 8'h00);
  endtask

  task automatic t_opc();
    logic [7:0] v;
    opsBusy = 1; opcArm = 1; step(); opcArm = 0;
    step(5);
    check("R9", "no completion while busy", evtRdData, 8'h00);
    opsBusy = 0; step();
    check("R9", "completion after busy drops", evtRdData, 8'h01);
    check("R8", "summary via opc enable", statusByte, 8'h20);
    readEvt(v);
    opsBusy = 1; step(3); opsBusy = 0; step(3);
    check("R9", "disarmed after firing", evtRdData, 8'h00);
  endtask

  task automatic t_opc_cancel();
    opsBusy = 1; opcArm = 1; step(); opcArm = 0;
    clearAllStb = 1; step(); clearAllStb = 0;
    opsBusy = 0; step(4);
    check("R5", "clear-all cancels request", evtRdData, 8'h00);
  endtask

  initial begin
    t_reset();
    t_layout();
    t_latch();
    t_collision();
    t_summary();
    t_clear_all();
    t_opc();
    t_opc_cancel();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule